// File: doc/BRIEF.md
# Sector test pattern generator and checker

This block produces and verifies test data for a disk write/read exerciser, one 512-byte sector at a time. A command names a first logical block address, a number of sectors, a fill pattern and a direction. In write direction the block presents the sector data on a valid/ready output stream. In read direction it accepts a stream on a valid/ready input, regenerates the same data internally and compares every beat against it.

Each sector is 32 beats of 128 bits. The low 64 bits of a sector's first beat hold a header: the sector's 48-bit address with 16 zero bits above it. Every other 32-bit word of the sector carries the selected pattern. The pattern sequence runs on across sector boundaries and restarts only with a new command.

When a read mismatches, a sticky flag rises. The flag keeps the address and beat of the first bad beat, the expected beat and the received beat. The transfer still runs to its end. A transfer that must be abandoned is cancelled by reset.

Top module: `spg_top`

## Requirements
- R1: After reset, busy, done, cfg_err, vfy_err and wr_valid are all low.
- R2: Word k of a beat occupies bits [32k+31:32k]. On beat 0 of each sector, bits [63:0] equal {16'h0000, sector LBA}. The first sector uses cfg_lba and each later sector adds one, modulo 2^48.
- R3: Pattern words fill every word outside the header, in ascending word order and then beat order. Pattern code 0 (increment) starts at 32'h0 and adds one per word. Code 1 (decrement) starts at 32'hFFFFFFFF and subtracts one per word. Neither restarts at a sector boundary.
- R4: Pattern code 2 fills every pattern word with 32'h00000000, and code 3 fills every pattern word with 32'hFFFFFFFF.
- R5: Pattern code 4 is a 32-bit LFSR. The first word is 32'h00000001. Each next word is {s[30:0], s[31]^s[21]^s[1]^s[0]} of the previous word s.
- R6: An accepted start raises busy in the next cycle. busy falls, and done pulses high for one cycle, in the cycle after the handshake of the last beat of the last sector. A start while busy is ignored, with no effect on data or on cfg_err.
- R7: A start with cfg_count equal to zero, or with a pattern code from 5 to 7, is rejected: cfg_err is high for exactly one cycle and busy stays low.
- R8: wr_valid is high only while busy in write direction (cfg_rd=0), and rd_ready is high only while busy in read direction (cfg_rd=1). wr_data holds stable while wr_valid is high and wr_ready is low. rd_data is ignored while rd_valid is low.
- R9: In read direction, the first accepted beat that differs from the regenerated beat sets vfy_err. That beat's sector LBA goes to err_lba and its beat index within the sector goes to err_beat. The expected beat goes to err_exp and the received beat to err_got. Later mismatches change none of these, and the transfer continues to done.
- R10: vfy_err stays high until the next accepted start, which clears it in the cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request, sampled when idle |
| cfg_lba | input | 48 | First sector address |
| cfg_count | input | 16 | Number of sectors |
| cfg_pat | input | 3 | Pattern code (0 inc, 1 dec, 2 zeros, 3 ones, 4 LFSR) |
| cfg_rd | input | 1 | 1 = verify incoming data, 0 = generate outgoing data |
| wr_valid | output | 1 | Outgoing beat valid |
| wr_ready | input | 1 | Outgoing beat accepted |
| wr_data | output | 128 | Outgoing beat |
| rd_valid | input | 1 | Incoming beat valid |
| rd_ready | output | 1 | Incoming beat accepted |
| rd_data | input | 128 | Incoming beat |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse at command end |
| cfg_err | output | 1 | One-cycle pulse on a rejected start |
| vfy_err | output | 1 | Sticky verify failure |
| err_lba | output | 48 | Sector address of first mismatch |
| err_beat | output | 5 | Beat index within that sector |
| err_exp | output | 128 | Expected beat at first mismatch |
| err_got | output | 128 | Received beat at first mismatch |

## Verification
The hardest state to reach from the ports is a second mismatch arriving after the first one has been captured, while the input stream is being throttled. The capture registers must ignore that second mismatch and the count must still reach done. To get there, the bench flips bits in chosen beats of a read stream whose rd_valid gaps follow a fixed cycle, and it fills the gaps with garbage data. Among the chosen beats are a header beat and a beat in a later sector. The bench also sends a write whose first LBA sits two below the 48-bit limit, so that the header address wraps through zero. In the middle of a stalled write it issues a start with bad fields, which must have no effect.

// File: rtl/spg_pkg.sv
package spg_pkg;

  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] LFSR_SEED = 32'h0000_0001;

  typedef enum logic [2:0] {
    PAT_INC  = 3'd0,
    PAT_DEC  = 3'd1,
    PAT_ZERO = 3'd2,
    PAT_ONE  = 3'd3,
    PAT_LFSR = 3'd4
  } pat_e;

  function automatic logic [WORD_W-1:0] lfsr_step(input logic [WORD_W-1:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [WORD_W-1:0] pat_init(input pat_e p);
    case (p)
      PAT_DEC:  return '1;
      PAT_LFSR: return LFSR_SEED;
      default:  return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] pat_word(input pat_e p, input logic [WORD_W-1:0] s);
    case (p)
      PAT_ZERO: return '0;
      PAT_ONE:  return '1;
      default:  return s;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] pat_adv(input pat_e p, input logic [WORD_W-1:0] s);
    case (p)
      PAT_INC:  return s + 1'b1;
      PAT_DEC:  return s - 1'b1;
      PAT_LFSR: return lfsr_step(s);
      default:  return s;
    endcase
  endfunction

endpackage

// File: rtl/spg_rst_sync.sv
module spg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/spg_gen.sv
module spg_gen
  import spg_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int LBA_W  = 48,
  parameter int HDR_W  = 64
) (
  input  pat_e              pat,
  input  logic [LBA_W-1:0]  lba,
  input  logic              first,
  input  logic [WORD_W-1:0] ps,
  output logic [DATA_W-1:0] data,
  output logic [WORD_W-1:0] ps_nxt
);
  localparam int WORDS  = DATA_W / WORD_W;
  localparam int HWORDS = HDR_W / WORD_W;

  logic [WORD_W-1:0] cur;

  always_comb begin
    cur  = ps;
    data = '0;
    if (first) data[HDR_W-1:0] = HDR_W'(lba);
    for (int k = 0; k < WORDS; k++) begin
      if (!(first && (k < HWORDS))) begin
        data[k*WORD_W +: WORD_W] = pat_word(pat, cur);
        cur = pat_adv(pat, cur);
      end
    end
    ps_nxt = cur;
  end
endmodule

// File: rtl/spg_seq.sv
module spg_seq
  import spg_pkg::*;
#(
  parameter int LBA_W = 48,
  parameter int CNT_W = 16,
  parameter int BEATS = 32,
  localparam int BW   = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LBA_W-1:0]  cfg_lba,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [2:0]        cfg_pat,
  input  logic              cfg_rd,
  input  logic              wr_ready,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] ps_nxt,
  output logic              busy,
  output logic              mode_rd,
  output pat_e              pat,
  output logic [LBA_W-1:0]  lba,
  output logic [BW-1:0]     beat,
  output logic [WORD_W-1:0] ps,
  output logic              fire,
  output logic              accept,
  output logic              done,
  output logic              cfg_err
);
  localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

  logic              busy_q, busy_d, rd_q, rd_d, done_q, done_d, cerr_q, cerr_d;
  pat_e              pat_q, pat_d;
  logic [LBA_W-1:0]  lba_q, lba_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [BW-1:0]     beat_q, beat_d;
  logic [WORD_W-1:0] ps_q, ps_d;
  logic              cfg_ok, reject;

  assign cfg_ok = (cfg_count != '0) && (cfg_pat <= 3'd4);
  assign accept = start && !busy_q && cfg_ok;
  assign reject = start && !busy_q && !cfg_ok;
  assign fire   = busy_q && (rd_q ? rd_valid : wr_ready);

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    pat_d  = pat_q;
    lba_d  = lba_q;
    left_d = left_q;
    beat_d = beat_q;
    ps_d   = ps_q;
    done_d = 1'b0;
    cerr_d = reject;
    if (accept) begin
      busy_d = 1'b1;
      rd_d   = cfg_rd;
      pat_d  = pat_e'(cfg_pat);
      lba_d  = cfg_lba;
      left_d = cfg_count;
      beat_d = '0;
      ps_d   = pat_init(pat_e'(cfg_pat));
    end else if (fire) begin
      ps_d = ps_nxt;
      if (beat_q == LAST_BEAT) begin
        beat_d = '0;
        lba_d  = lba_q + 1'b1;
        left_d = left_q - 1'b1;
        if (left_q == CNT_W'(1)) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end else begin
        beat_d = beat_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      pat_q  <= PAT_INC;
      lba_q  <= '0;
      left_q <= '0;
      beat_q <= '0;
      ps_q   <= '0;
      done_q <= 1'b0;
      cerr_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      pat_q  <= pat_d;
      lba_q  <= lba_d;
      left_q <= left_d;
      beat_q <= beat_d;
      ps_q   <= ps_d;
      done_q <= done_d;
      cerr_q <= cerr_d;
    end
  end

  assign busy    = busy_q;
  assign mode_rd = rd_q;
  assign pat     = pat_q;
  assign lba     = lba_q;
  assign beat    = beat_q;
  assign ps      = ps_q;
  assign done    = done_q;
  assign cfg_err = cerr_q;

  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R7
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);
endmodule

// File: rtl/spg_cmp.sv
module spg_cmp #(
  parameter int DATA_W = 128,
  parameter int LBA_W  = 48,
  parameter int BW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              check,
  input  logic [DATA_W-1:0] exp_data,
  input  logic [DATA_W-1:0] got_data,
  input  logic [LBA_W-1:0]  lba,
  input  logic [BW-1:0]     beat,
  output logic              vfy_err,
  output logic [LBA_W-1:0]  err_lba,
  output logic [BW-1:0]     err_beat,
  output logic [DATA_W-1:0] err_exp,
  output logic [DATA_W-1:0] err_got
);
  logic              vf_q, vf_d;
  logic [LBA_W-1:0]  lba_q, lba_d;
  logic [BW-1:0]     beat_q, beat_d;
  logic [DATA_W-1:0] exp_q, exp_d, got_q, got_d;
  logic              mism, grab;

  assign mism = check && (exp_data != got_data);
  assign grab = mism && !vf_q;

  always_comb begin
    vf_d   = vf_q;
    lba_d  = lba_q;
    beat_d = beat_q;
    exp_d  = exp_q;
    got_d  = got_q;
    if (clr) begin
      vf_d   = 1'b0;
      lba_d  = '0;
      beat_d = '0;
      exp_d  = '0;
      got_d  = '0;
    end else if (grab) begin
      vf_d   = 1'b1;
      lba_d  = lba;
      beat_d = beat;
      exp_d  = exp_data;
      got_d  = got_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vf_q   <= 1'b0;
      lba_q  <= '0;
      beat_q <= '0;
      exp_q  <= '0;
      got_q  <= '0;
    end else begin
      vf_q   <= vf_d;
      lba_q  <= lba_d;
      beat_q <= beat_d;
      exp_q  <= exp_d;
      got_q  <= got_d;
    end
  end

  assign vfy_err  = vf_q;
  assign err_lba  = lba_q;
  assign err_beat = beat_q;
  assign err_exp  = exp_q;
  assign err_got  = got_q;

  // R9
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_err && !clr) |=> vfy_err);
  // R9
  first_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_err && !clr) |=> ($stable(err_lba) && $stable(err_beat) && $stable(err_got)));
  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !vfy_err);
endmodule

// File: rtl/spg_top.sv
module spg_top
  import spg_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int LBA_W  = 48,
  parameter int CNT_W  = 16,
  parameter int BEATS  = 32,
  localparam int BW    = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LBA_W-1:0]  cfg_lba,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [2:0]        cfg_pat,
  input  logic              cfg_rd,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              cfg_err,
  output logic              vfy_err,
  output logic [LBA_W-1:0]  err_lba,
  output logic [BW-1:0]     err_beat,
  output logic [DATA_W-1:0] err_exp,
  output logic [DATA_W-1:0] err_got
);
  logic              rst_s, mode_rd, fire, accept;
  pat_e              pat;
  logic [LBA_W-1:0]  lba;
  logic [BW-1:0]     beat;
  logic [WORD_W-1:0] ps, ps_nxt;
  logic [DATA_W-1:0] beat_data;

  spg_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_s));

  spg_seq #(.LBA_W(LBA_W), .CNT_W(CNT_W), .BEATS(BEATS)) u_seq (
    .clk(clk), .rst_n(rst_s), .start(start), .cfg_lba(cfg_lba),
    .cfg_count(cfg_count), .cfg_pat(cfg_pat), .cfg_rd(cfg_rd),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .ps_nxt(ps_nxt),
    .busy(busy), .mode_rd(mode_rd), .pat(pat), .lba(lba), .beat(beat),
    .ps(ps), .fire(fire), .accept(accept), .done(done), .cfg_err(cfg_err)
  );

  spg_gen #(.DATA_W(DATA_W), .LBA_W(LBA_W), .HDR_W(64)) u_gen (
    .pat(pat), .lba(lba), .first(beat == '0), .ps(ps),
    .data(beat_data), .ps_nxt(ps_nxt)
  );

  spg_cmp #(.DATA_W(DATA_W), .LBA_W(LBA_W), .BW(BW)) u_cmp (
    .clk(clk), .rst_n(rst_s), .clr(accept), .check(fire && mode_rd),
    .exp_data(beat_data), .got_data(rd_data), .lba(lba), .beat(beat),
    .vfy_err(vfy_err), .err_lba(err_lba), .err_beat(err_beat),
    .err_exp(err_exp), .err_got(err_got)
  );

  assign wr_valid = busy && !mode_rd;
  assign rd_ready = busy && mode_rd;
  assign wr_data  = beat_data;

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));
  // R8
  one_dir_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({wr_valid, rd_ready}));
endmodule

// File: tb/test_spg_top.sv
module test_spg_top;
  localparam int CLK_PERIOD = 10;

  logic         clk, rst_n, start, cfg_rd, wr_ready, rd_valid;
  logic [47:0]  cfg_lba;
  logic [15:0]  cfg_count;
  logic [2:0]   cfg_pat;
  logic         wr_valid, rd_ready, busy, done, cfg_err, vfy_err;
  logic [127:0] wr_data, rd_data, err_exp, err_got;
  logic [47:0]  err_lba;
  logic [4:0]   err_beat;

  spg_top i_spg_top (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_lba(cfg_lba),
    .cfg_count(cfg_count), .cfg_pat(cfg_pat), .cfg_rd(cfg_rd),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .done(done), .cfg_err(cfg_err), .vfy_err(vfy_err),
    .err_lba(err_lba), .err_beat(err_beat), .err_exp(err_exp), .err_got(err_got)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R6 watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // reference model
  logic [47:0] m_lba;
  int          m_beat;
  logic [31:0] m_ps;
  logic [2:0]  m_pat;

  function automatic logic [31:0] m_step(input logic [2:0] p, input logic [31:0] s);
    case (p)
      3'd0: return s + 32'd1;
      3'd1: return s - 32'd1;
      3'd4: return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
      default: return s;
    endcase
  endfunction

  function automatic logic [31:0] m_val(input logic [2:0] p, input logic [31:0] s);
    if (p == 3'd2) return 32'h0;
    if (p == 3'd3) return 32'hFFFF_FFFF;
    return s;
  endfunction

  task automatic m_init(input logic [47:0] lba, input logic [2:0] p);
    m_lba = lba; m_beat = 0; m_pat = p;
    m_ps = (p == 3'd1) ? 32'hFFFF_FFFF : (p == 3'd4) ? 32'h1 : 32'h0;
  endtask

  task automatic m_beat_data(output logic [127:0] d, output logic [31:0] nps);
    logic [31:0] s;
    s = m_ps; d = '0;
    for (int w = 0; w < 4; w++) begin
      if (m_beat == 0 && w < 2) begin
        if (w == 0) d[63:0] = {16'h0, m_lba};
      end else begin
        d[w*32 +: 32] = m_val(m_pat, s);
        s = m_step(m_pat, s);
      end
    end
    nps = s;
  endtask

  task automatic m_adv(input logic [31:0] nps);
    m_ps = nps;
    if (m_beat == 31) begin m_beat = 0; m_lba = m_lba + 48'd1; end
    else m_beat++;
  endtask

  task automatic do_start(input logic [47:0] lba, input logic [15:0] cnt,
                          input logic [2:0] p, input logic rd);
    cfg_lba = lba; cfg_count = cnt; cfg_pat = p; cfg_rd = rd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
  endtask

  task automatic run_write(input int total, input string req, input int poke);
    int seen = 0, cyc = 0;
    bit hold = 0, poked = 0;
    logic [127:0] held, e;
    logic [31:0] nps;
    while (seen < total) begin
      wr_ready = ((cyc % 3) != 1);
      if (poked) begin
        start = 1'b0; poked = 0;
        chk(cfg_err == 1'b0 && busy == 1'b1, "R6", "start while busy", {126'd0, cfg_err, busy}, 128'd1);
      end
      if (seen == poke && cyc > 0 && !hold) begin
        start = 1'b1; cfg_lba = 48'h123; cfg_count = 16'd0; cfg_pat = 3'd7; poked = 1; poke = -1;
      end
      #1;
      if (hold) chk(wr_data == held, "R8", "stalled wr_data", wr_data, held);
      hold = 0;
      if (!wr_valid) chk(0, "R8", "wr_valid while busy", {127'd0, wr_valid}, 128'd1);
      else if (wr_ready) begin
        m_beat_data(e, nps);
        chk(wr_data == e, req, $sformatf("beat %0d", seen), wr_data, e);
        m_adv(nps);
        seen++;
      end else begin
        hold = 1; held = wr_data;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    wr_ready = 1'b0;
    #1;
    chk(done == 1'b1 && busy == 1'b0, "R6", "done after last beat", {126'd0, done, busy}, 128'd2);
    @(negedge clk); #1;
    chk(done == 1'b0, "R6", "done one cycle", {127'd0, done}, 128'd0);
  endtask

  task automatic run_read(input int total, input int c1, input int c2, input logic [127:0] mask);
    int seen = 0, cyc = 0;
    logic [127:0] e, f_exp, f_got;
    logic [47:0] f_lba;
    int f_beat;
    logic [31:0] nps;
    f_lba = '0; f_beat = 0; f_exp = '0; f_got = '0;
    while (seen < total) begin
      rd_valid = ((cyc % 4) != 2);
      m_beat_data(e, nps);
      if (rd_valid) rd_data = (seen == c1 || seen == c2) ? (e ^ mask) : e;
      else          rd_data = ~e;
      #1;
      if (!rd_ready) chk(0, "R8", "rd_ready while busy", {127'd0, rd_ready}, 128'd1);
      if (rd_valid && rd_ready) begin
        if (seen == c1) begin f_lba = m_lba; f_beat = m_beat; f_exp = e; f_got = e ^ mask; end
        m_adv(nps);
        seen++;
      end
      @(negedge clk);
      cyc++;
    end
    rd_valid = 1'b0;
    #1;
    chk(done == 1'b1 && busy == 1'b0, "R9", "read reaches done", {126'd0, done, busy}, 128'd2);
    if (c1 < 0) begin
      chk(vfy_err == 1'b0, "R9", "clean read", {127'd0, vfy_err}, 128'd0);
    end else begin
      chk(vfy_err == 1'b1, "R9", "vfy_err set", {127'd0, vfy_err}, 128'd1);
      chk(err_lba == f_lba, "R9", "err_lba", {80'd0, err_lba}, {80'd0, f_lba});
      chk(err_beat == f_beat[4:0], "R9", "err_beat", {123'd0, err_beat}, 128'(f_beat));
      chk(err_exp == f_exp, "R9", "err_exp", err_exp, f_exp);
      chk(err_got == f_got, "R9", "err_got", err_got, f_got);
    end
  endtask

  logic [47:0] wlba [5];

  initial begin
    rst_n = 1'b0; start = 1'b0; cfg_lba = '0; cfg_count = '0; cfg_pat = '0; cfg_rd = 1'b0;
    wr_ready = 1'b0; rd_valid = 1'b0; rd_data = '0;
    wlba[0] = 48'hFFFF_FFFF_FFFE; wlba[1] = 48'h0; wlba[2] = 48'h1234_5678_9ABC;
    wlba[3] = 48'h0000_0000_0100; wlba[4] = 48'h8000_0000_0001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1
    chk({busy, done, cfg_err, vfy_err, wr_valid} == 5'b0, "R1", "reset outputs",
        {123'd0, busy, done, cfg_err, vfy_err, wr_valid}, 128'd0);

    // R2 R3 R4 R5: write every pattern, 3 sectors each
    for (int p = 0; p < 5; p++) begin
      string rq;
      rq = (p < 2) ? "R3" : (p < 4) ? "R4" : "R5";
      @(negedge clk);
      m_init(wlba[p], 3'(p));
      do_start(wlba[p], 16'd3, 3'(p), 1'b0);
      chk(busy == 1'b1 && cfg_err == 1'b0, "R6", "busy after start", {126'd0, busy, cfg_err}, 128'd2);
      run_write(96, (p == 0) ? "R2" : rq, (p == 0) ? 40 : -1);
    end

    // clean reads for every pattern
    for (int p = 0; p < 5; p++) begin
      @(negedge clk);
      m_init(48'h55 + 48'(p), 3'(p));
      do_start(48'h55 + 48'(p), 16'd2, 3'(p), 1'b1);
      run_read(64, -1, -1, '0);
    end

    // R9: two mismatches in an LFSR read, second ignored
    @(negedge clk);
    m_init(48'hABCDE, 3'd4);
    do_start(48'hABCDE, 16'd3, 3'd4, 1'b1);
    run_read(96, 37, 70, {64'h1, 64'h8000_0000_0000_0000});

    // R10: new start clears vfy_err; this read corrupts a header
    @(negedge clk);
    m_init(48'h7, 3'd2);
    do_start(48'h7, 16'd1, 3'd2, 1'b1);
    chk(vfy_err == 1'b0, "R10", "cleared by start", {127'd0, vfy_err}, 128'd0);
    run_read(32, 0, -1, {64'h0, 64'h0000_0000_0000_0001});

    // R10: sticky across idle
    repeat (3) @(negedge clk);
    #1;
    chk(vfy_err == 1'b1, "R10", "sticky while idle", {127'd0, vfy_err}, 128'd1);

    // R7: rejects
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 0) do_start(48'h1, 16'd0, 3'd0, 1'b0);
      else        do_start(48'h1, 16'd1, 3'(4 + k), 1'b0);
      chk(cfg_err == 1'b1 && busy == 1'b0 && wr_valid == 1'b0, "R7", "reject pulse",
          {125'd0, cfg_err, busy, wr_valid}, 128'd4);
      @(negedge clk); #1;
      chk(cfg_err == 1'b0 && busy == 1'b0, "R7", "reject one cycle", {126'd0, cfg_err, busy}, 128'd0);
    end
    chk(vfy_err == 1'b1, "R10", "reject keeps vfy_err", {127'd0, vfy_err}, 128'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule